// File: doc/BRIEF.md
# Half-Duplex Converter Digital Front-End

This block is the digital side of a transmit/receive converter pair that shares one clock and runs half-duplex. Two enable inputs pick one of three modes. Transmit drives a 7-bit DAC word. Receive presents a 5-bit ADC result. Shutdown idles both paths.

On the transmit side, the DAC word is captured on the falling clock edge. It is then committed to the converter register on the next rising edge. On the receive side, the converter level is sampled on the falling edge and becomes a two's-complement code on the output bus at the following rising edge. The output bus changes only on rising edges, except that it is held at zero in shutdown.

Leaving shutdown starts a wake-up interval counted in clock cycles. The count is derived from the clock frequency and a 2.4 µs bound. During this interval `ready_o` stays low and neither path updates.

Top module: `hdx_conv_if`

## Requirements
- R1: The enable pair (rx_en_i, tx_en_i) selects the mode: (0,1) is transmit, (1,0) is receive, and (0,0) or (1,1) is shutdown.
- R2: In transmit mode with ready_o high, the value on dac_word_i at a falling edge appears on dac_o after the next rising edge. A change to dac_word_i after that falling edge does not alter the committed value.
- R3: dac_o changes only on rising clock edges. It keeps its previous value when sampled between a falling edge and the next rising edge.
- R4: Outside transmit mode (receive or shutdown), dac_o holds its last value whatever dac_word_i does.
- R5: adc_code_o is the two's-complement code of the unsigned level on adc_level_i, equal to level minus 16 in 5 bits. Level 0 gives 10000, level 15 gives 11111, level 16 gives 00000 and level 31 gives 01111, with the MSB on bit 4.
- R6: In receive mode with ready_o high, a level sampled at a falling edge appears on adc_code_o at the next rising edge, which is a half-cycle delay. adc_code_o does not change at the falling edge.
- R7: In shutdown, adc_code_o is all zeros.
- R8: In transmit mode, adc_code_o holds its last value.
- R9: After the mode leaves shutdown, ready_o stays low for WAKE_CYCLES-1 rising edges and goes high after the WAKE_CYCLES-th. With defaults this is 120 cycles of 20 ns, which is 2.4 µs. ready_o is low in shutdown.
- R10: While ready_o is low, neither dac_o nor adc_code_o takes a new converter value.
- R11: While rst_ni is low, the block is in shutdown with dac_o = 0, adc_code_o = 0 and ready_o = 0.
- R12: Switching directly between transmit and receive does not restart the wake-up interval, so ready_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared converter clock, both edges used |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable |
| tx_en_i | input | 1 | Transmit enable |
| dac_word_i | input | 7 | DAC word to capture |
| dac_o | output | 7 | Committed DAC register |
| adc_level_i | input | 5 | Unsigned quantizer level, 0 = negative full scale |
| adc_code_o | output | 5 | Two's-complement ADC code, MSB on bit 4 |
| ready_o | output | 1 | High once the wake-up interval has elapsed in an active mode |

## Verification
The assertions assume that the enables and data inputs are stable around both clock edges. They also assume that a mode seen at one edge is the mode in force for the half-cycle that follows. The stimulus therefore changes every input 5 ns after a rising or falling edge. That leaves each edge with settled values. The bench also deliberately changes data after the falling-edge capture, to show that only the falling-edge value is committed.

// File: rtl/hdx_pkg.sv
`timescale 1ns/1ps
package hdx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_TX  = 2'b01,
    MODE_RX  = 2'b10
  } mode_e;

  function automatic mode_e decode_mode(input logic rx_en, input logic tx_en);
    if (rx_en && !tx_en) return MODE_RX;
    if (!rx_en && tx_en) return MODE_TX;
    return MODE_OFF;
  endfunction
endpackage

// File: rtl/hdx_mode_ctrl.sv
`timescale 1ns/1ps
module hdx_mode_ctrl
  import hdx_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 120
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rx_en_i,
  input  logic  tx_en_i,
  output mode_e mode_o,
  output logic  ready_o
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          active;

  assign mode_o  = decode_mode(rx_en_i, tx_en_i);
  assign active  = (mode_o != MODE_OFF);
  assign ready_o = active && (cnt_q == '0);

  // reload in shutdown, count down once active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= CW'(WAKE_CYCLES);
    else if (!active)          cnt_q <= CW'(WAKE_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assert_wake_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_ready_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(mode_o) != MODE_OFF));
  assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WAKE_CYCLES));
endmodule

// File: rtl/hdx_dac_path.sv
`timescale 1ns/1ps
module hdx_dac_path
  import hdx_pkg::*;
#(
  parameter int unsigned DAC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             ready_i,
  input  logic [DAC_W-1:0] word_i,
  output logic [DAC_W-1:0] dac_o
);
  logic [DAC_W-1:0] in_q, dac_q;
  logic             tx_ok;

  assign tx_ok = (mode_i == MODE_TX) && ready_i;

  // input register: falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                in_q <= '0;
    else if (mode_i == MODE_TX) in_q <= word_i;
  end

  // converter register: rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dac_q <= '0;
    else if (tx_ok) dac_q <= in_q;
  end

  assign dac_o = dac_q;

  assert_dac_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ok |=> $stable(dac_q));
  assert_dac_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok |=> (dac_q == $past(in_q)));
endmodule

// File: rtl/hdx_adc_path.sv
`timescale 1ns/1ps
module hdx_adc_path
  import hdx_pkg::*;
#(
  parameter int unsigned ADC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             ready_i,
  input  logic [ADC_W-1:0] level_i,
  output logic [ADC_W-1:0] code_o
);
  logic [ADC_W-1:0] samp_q, code_q, code_d;
  logic             rx_ok, off;

  assign rx_ok = (mode_i == MODE_RX) && ready_i;
  assign off   = (mode_i == MODE_OFF);

  // offset binary level -> two's complement
  assign code_d = {~samp_q[ADC_W-1], samp_q[ADC_W-2:0]};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                samp_q <= '0;
    else if (mode_i == MODE_RX) samp_q <= level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (off)   code_q <= '0;
    else if (rx_ok) code_q <= code_d;
  end

  // pins never high while shut down
  assign code_o = off ? '0 : code_q;

  assert_adc_off_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |=> (code_q == '0));
  assert_adc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ok && !off) |=> $stable(code_q));
  assert_adc_pin_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |-> (code_o == '0));
endmodule

// File: rtl/hdx_conv_if.sv
`timescale 1ns/1ps
module hdx_conv_if
  import hdx_pkg::*;
#(
  parameter int unsigned DAC_W   = 7,
  parameter int unsigned ADC_W   = 5,
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned WAKE_NS = 2400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic [DAC_W-1:0] dac_word_i,
  output logic [DAC_W-1:0] dac_o,
  input  logic [ADC_W-1:0] adc_level_i,
  output logic [ADC_W-1:0] adc_code_o,
  output logic             ready_o
);
  localparam int unsigned WAKE_CYCLES = (CLK_MHZ * WAKE_NS) / 1000;

  mode_e mode;
  logic  ready;

  hdx_mode_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_en_i (rx_en_i),
    .tx_en_i (tx_en_i),
    .mode_o  (mode),
    .ready_o (ready)
  );

  hdx_dac_path #(.DAC_W(DAC_W)) u_dac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .ready_i (ready),
    .word_i  (dac_word_i),
    .dac_o   (dac_o)
  );

  hdx_adc_path #(.ADC_W(ADC_W)) u_adc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .ready_i (ready),
    .level_i (adc_level_i),
    .code_o  (adc_code_o)
  );

  assign ready_o = ready;

  assert_no_dac_move_unready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(dac_o));
  assert_switch_keeps_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (rx_en_i != tx_en_i)) |=> (ready_o || (rx_en_i == tx_en_i)));
endmodule

// File: tb/hdx_conv_if_tb_top.sv
`timescale 1ns/1ps
module hdx_conv_if_tb_top;
  localparam int W = 120;

  logic       clk = 1'b0;
  logic       rst_n, rx_en, tx_en, ready;
  logic [6:0] dac_w, dac;
  logic [4:0] lvl, code;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hdx_conv_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .dac_word_i(dac_w), .dac_o(dac), .adc_level_i(lvl),
    .adc_code_o(code), .ready_o(ready)
  );

  function automatic int exp_code(input logic [4:0] l);
    logic [4:0] c;
    c = 5'(int'(l) - 16);
    return int'(c);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #5; endtask
  task automatic half; @(negedge clk); #5; endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [6:0] prev_dac;
    logic [4:0] prev_code, l;
    logic [4:0] dir_lv [4];
    dir_lv[0] = 5'd0; dir_lv[1] = 5'd15; dir_lv[2] = 5'd16; dir_lv[3] = 5'd31;
    void'($urandom(32'd1234));
    rst_n = 0; rx_en = 0; tx_en = 0; dac_w = 7'h2A; lvl = 5'd7;
    repeat (3) tick();
    chk("R11 dac", int'(dac), 0);
    chk("R11 adc", int'(code), 0);
    chk("R11 ready", int'(ready), 0);
    rst_n = 1;
    tick();

    // R1 (0,1) transmit, R9 wake, R10 no update while waking
    rx_en = 0; tx_en = 1; dac_w = 7'h55;
    for (int k = 1; k <= W; k++) begin
      tick();
      chk("R9 ready", int'(ready), (k == W) ? 1 : 0);
      chk("R10 dac", int'(dac), 0);
    end
    tick();
    chk("R1 tx first commit", int'(dac), 'h55);
    prev_dac = 7'h55;

    // R2/R3 transmit
    for (int i = 0; i < 24; i++) begin
      logic [6:0] w;
      w = (i == 0) ? 7'h7F : (i == 1) ? 7'h00 : 7'($urandom);
      dac_w = w;
      half();
      chk("R3 dac stable at fall", int'(dac), int'(prev_dac));
      dac_w = ~w;
      tick();
      chk("R2 dac commit", int'(dac), int'(w));
      prev_dac = w;
    end

    // direct switch to receive
    rx_en = 1; tx_en = 0;
    prev_code = code;
    for (int i = 0; i < 34; i++) begin
      l = (i < 4) ? dir_lv[i] : 5'($urandom);
      lvl = l;
      dac_w = 7'($urandom);
      half();
      chk("R6 code stable at fall", int'(code), int'(prev_code));
      lvl = 5'($urandom);
      tick();
      chk("R5 code", int'(code), exp_code(l));
      chk("R4 dac hold rx", int'(dac), int'(prev_dac));
      if (i == 0) chk("R12 ready tx->rx", int'(ready), 1);
      prev_code = code;
    end

    // back to transmit: ADC holds
    rx_en = 0; tx_en = 1;
    for (int i = 0; i < 5; i++) begin
      logic [6:0] w;
      w = 7'($urandom);
      dac_w = w;
      lvl = 5'($urandom);
      tick();
      chk("R8 adc hold", int'(code), int'(prev_code));
      chk("R12 ready rx->tx", int'(ready), 1);
      chk("R2 dac", int'(dac), int'(w));
      prev_dac = w;
    end

    // shutdown via (1,1)
    rx_en = 1; tx_en = 1;
    #1;
    chk("R7 adc zero", int'(code), 0);
    chk("R9 ready off", int'(ready), 0);
    for (int i = 0; i < 4; i++) begin
      dac_w = 7'($urandom);
      lvl = 5'($urandom);
      tick();
      chk("R4 dac hold off", int'(dac), int'(prev_dac));
      chk("R7 adc zero", int'(code), 0);
      chk("R1 (1,1) off", int'(ready), 0);
    end

    // wake into receive
    rx_en = 1; tx_en = 0; lvl = 5'd20;
    for (int k = 1; k <= W; k++) begin
      tick();
      chk("R9 ready rx wake", int'(ready), (k == W) ? 1 : 0);
      chk("R10 adc", int'(code), 0);
    end
    tick();
    chk("R5 code after wake", int'(code), exp_code(5'd20));

    // shutdown via (0,0)
    rx_en = 0; tx_en = 0;
    tick();
    chk("R1 (0,0) adc", int'(code), 0);
    chk("R1 (0,0) ready", int'(ready), 0);
    chk("R4 dac hold", int'(dac), int'(prev_dac));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule